// File: doc/BRIEF.md
# Nibble-Addressed Accumulator Processor

This block is a small stored-program processor with a single 8-bit accumulator and a 16-word internal RAM. Program and data share that RAM. Each instruction word packs an operation code and a memory address into one byte. The processor walks through fetch, decode and execute in separate clock cycles, so every movement of a value becomes visible on its own cycle. That includes program counter to address register, RAM to data register, data register to instruction register, and the operand traffic during execute. The current step is reported on a phase output.

Before a run, the RAM is filled through a preload port, normally while reset is held. Reset leaves the RAM contents alone, so a program can be loaded once and restarted. The processor reads external values through an input port: the input instruction waits until the valid line is asserted. It emits values through an output port with a single-cycle strobe. After the halt instruction it stops for good and raises a halted flag that stays up until the next reset. Unused operation codes, and input/output words with any other selector, do nothing beyond their fetch and decode.

Top module: `nac_cpu`

## Requirements
- R1: While reset is low, and on its release, phase reads 0, halted and the output strobe are low, and the program counter is 0, so execution begins at address 0. Reset does not alter RAM contents.
- R2: Phase codes are 0 fetch-address, 1 fetch-read, 2 fetch-latch, 3 decode, 4 execute, 5 memory-execute and 6 halted. Every instruction passes through phases 0, 1, 2, 3 and 4 in that order. Load, store, add and subtract then add phase 5 before the next fetch.
- R3: In an instruction word, bits 7:4 are the opcode and bits 3:0 the address. The opcodes are: 0000 halt, 0001 add, 0010 subtract, 0011 store, 0101 load, 0110 branch always, 0111 branch if zero, 1000 branch if positive, 1001 I/O. For I/O, address 0001 means input and 0010 means output.
- R4: Add and subtract combine the accumulator with the addressed RAM word and wrap modulo 256.
- R5: Load copies the addressed word into the accumulator. Store writes the accumulator into the addressed word.
- R6: Branch always sets the program counter to the address field. Branch if zero does so only when the accumulator equals 0. Branch if positive does so when accumulator bit 7 is 0, which includes zero.
- R7: While input waits without valid, `in_wait_o` is high, phase holds at 4, and no output or halt occurs. On the first cycle with valid, `in_data_i` enters the accumulator.
- R8: Output raises `out_stb_o` for exactly one cycle, the cycle after its execute phase, with `out_data_o` equal to the accumulator.
- R9: After halt, `halted_o` is high and phase reads 6 until reset, and no further strobes appear.
- R10: A cycle with `load_en_i` high writes `load_data_i` at `load_addr_i`, and this write takes priority over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_en_i | input | 1 | RAM preload write enable |
| load_addr_i | input | 4 | RAM preload address |
| load_data_i | input | 8 | RAM preload data |
| in_valid_i | input | 1 | Input value is available |
| in_data_i | input | 8 | Input value |
| in_wait_o | output | 1 | An input instruction is waiting for a value |
| out_data_o | output | 8 | Last output value |
| out_stb_o | output | 1 | One-cycle pulse marking a new output value |
| halted_o | output | 1 | Processor has executed halt |
| phase_o | output | 3 | Current step code |

## Verification
The store-to-RAM assertion assumes that the preload port stays idle while a program is running. The bench therefore preloads only while reset is held low. The input-stall properties treat `in_valid_i` as a clean level sampled at the clock edge. The bench changes it only on falling edges, raises it only while `in_wait_o` is high, and lowers it one cycle later. The vector table and the directed programs use only the listed opcodes, place data words above the code, and end each program with halt, so every run stays inside the 16-word space.

// File: rtl/nac_pkg.sv
package nac_pkg;

  typedef enum logic [2:0] {
    PH_FETCH_ADDR  = 3'd0,
    PH_FETCH_READ  = 3'd1,
    PH_FETCH_LATCH = 3'd2,
    PH_DECODE      = 3'd3,
    PH_EXEC        = 3'd4,
    PH_MEM         = 3'd5,
    PH_HALT        = 3'd6
  } phase_e;

  localparam logic [3:0] OP_HALT = 4'b0000;
  localparam logic [3:0] OP_ADD  = 4'b0001;
  localparam logic [3:0] OP_SUB  = 4'b0010;
  localparam logic [3:0] OP_STO  = 4'b0011;
  localparam logic [3:0] OP_LOAD = 4'b0101;
  localparam logic [3:0] OP_JMP  = 4'b0110;
  localparam logic [3:0] OP_JZ   = 4'b0111;
  localparam logic [3:0] OP_JP   = 4'b1000;
  localparam logic [3:0] OP_IO   = 4'b1001;

  localparam logic [3:0] IO_SEL_IN  = 4'b0001;
  localparam logic [3:0] IO_SEL_OUT = 4'b0010;

endpackage

// File: rtl/nac_ram.sv
module nac_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pl_en_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  // preload port has priority over a processor store
  always_comb begin
    wr_en   = pl_en_i | cpu_we_i;
    wr_addr = pl_en_i ? pl_addr_i : cpu_addr_i;
    wr_data = pl_en_i ? pl_data_i : cpu_wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  // read is combinational onto the data bus
  assign rdata_o = mem_q[cpu_addr_i];

  a_r5_store_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && !pl_en_i) |=> (mem_q[$past(cpu_addr_i)] == $past(cpu_wdata_i)));

endmodule

// File: rtl/nac_alu.sv
module nac_alu #(
  parameter int DATA_W = 8
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sub(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + (~y) + DATA_W'(1);
  endfunction

  assign res_o = sub_i ? wrap_sub(a_i, b_i) : wrap_add(a_i, b_i);

  always_comb begin
    if (sub_i) a_r4_sub_inverse: assert (DATA_W'(res_o + b_i) == a_i);
  end

endmodule

// File: rtl/nac_seq.sv
module nac_seq
  import nac_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   is_halt_i,
  input  logic   is_in_i,
  input  logic   is_mem_i,
  input  logic   in_valid_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_FETCH_ADDR:  phase_d = PH_FETCH_READ;
      PH_FETCH_READ:  phase_d = PH_FETCH_LATCH;
      PH_FETCH_LATCH: phase_d = PH_DECODE;
      PH_DECODE:      phase_d = PH_EXEC;
      PH_EXEC: begin
        if (is_halt_i)                phase_d = PH_HALT;
        else if (is_in_i && !in_valid_i) phase_d = PH_EXEC;
        else if (is_mem_i)            phase_d = PH_MEM;
        else                          phase_d = PH_FETCH_ADDR;
      end
      PH_MEM:         phase_d = PH_FETCH_ADDR;
      PH_HALT:        phase_d = PH_HALT;
      default:        phase_d = PH_FETCH_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_FETCH_ADDR;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  a_r2_fetch_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH_ADDR) |=> (phase_q == PH_FETCH_READ));
  a_r2_fetch_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH_READ) |=> (phase_q == PH_FETCH_LATCH));
  a_r2_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH_LATCH) |=> (phase_q == PH_DECODE));
  a_r2_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DECODE) |=> (phase_q == PH_EXEC));
  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HALT) |=> (phase_q == PH_HALT));
  a_r7_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && is_in_i && !in_valid_i && !is_halt_i) |=> (phase_q == PH_EXEC));

endmodule

// File: rtl/nac_cpu.sv
module nac_cpu
  import nac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_wait_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_stb_o,
  output logic              halted_o,
  output logic [2:0]        phase_o
);
  localparam int OPC_W = DATA_W - ADDR_W;

  // architectural registers
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mdr_q, acc_q;
  logic [DATA_W-1:0] out_q;
  logic              stb_q;

  // buses and decoded fields
  logic [ADDR_W-1:0] addr_bus;
  logic [DATA_W-1:0] data_bus;
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] opa;
  logic [DATA_W-1:0] alu_res;
  phase_e            phase;

  // named internal events
  logic is_halt, is_in, is_out, is_mem, is_sub;
  logic ev_exec, ev_mem, ev_take_in, ev_branch, ev_store;

  assign opc      = ir_q[DATA_W-1:ADDR_W];
  assign opa      = ir_q[ADDR_W-1:0];
  assign addr_bus = mar_q;

  always_comb begin
    is_halt = (opc == OP_HALT);
    is_in   = (opc == OP_IO) && (opa == IO_SEL_IN);
    is_out  = (opc == OP_IO) && (opa == IO_SEL_OUT);
    is_mem  = (opc == OP_ADD) || (opc == OP_SUB) || (opc == OP_STO) || (opc == OP_LOAD);
    is_sub  = (opc == OP_SUB);
  end

  always_comb begin
    ev_exec    = (phase == PH_EXEC);
    ev_mem     = (phase == PH_MEM);
    ev_take_in = ev_exec && is_in && in_valid_i;
    ev_store   = ev_mem && (opc == OP_STO);
    unique case (opc)
      OP_JMP:  ev_branch = ev_exec;
      OP_JZ:   ev_branch = ev_exec && (acc_q == '0);
      OP_JP:   ev_branch = ev_exec && !acc_q[DATA_W-1];
      default: ev_branch = 1'b0;
    endcase
  end

  nac_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .is_halt_i  (is_halt),
    .is_in_i    (is_in),
    .is_mem_i   (is_mem),
    .in_valid_i (in_valid_i),
    .phase_o    (phase)
  );

  nac_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pl_en_i     (load_en_i),
    .pl_addr_i   (load_addr_i),
    .pl_data_i   (load_data_i),
    .cpu_we_i    (ev_store),
    .cpu_addr_i  (addr_bus),
    .cpu_wdata_i (mdr_q),
    .rdata_o     (data_bus)
  );

  nac_alu #(.DATA_W(DATA_W)) u_alu (
    .sub_i (is_sub),
    .a_i   (acc_q),
    .b_i   (data_bus),
    .res_o (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      out_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (phase)
        PH_FETCH_ADDR:  mar_q <= pc_q;
        PH_FETCH_READ: begin
          mdr_q <= data_bus;
          pc_q  <= pc_q + ADDR_W'(1);
        end
        PH_FETCH_LATCH: ir_q <= mdr_q;
        PH_EXEC: begin
          if (is_mem) mar_q <= opa;
          if (opc == OP_STO) mdr_q <= acc_q;
          if (ev_branch) pc_q <= opa;
          if (ev_take_in) acc_q <= in_data_i;
          if (is_out) begin
            out_q <= acc_q;
            stb_q <= 1'b1;
          end
        end
        PH_MEM: begin
          if (opc == OP_LOAD) begin
            mdr_q <= data_bus;
            acc_q <= data_bus;
          end else if (opc == OP_ADD || opc == OP_SUB) begin
            mdr_q <= data_bus;
            acc_q <= alu_res;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_wait_o  = ev_exec && is_in;
  assign out_data_o = out_q;
  assign out_stb_o  = stb_q;
  assign halted_o   = (phase == PH_HALT);
  assign phase_o    = phase;

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FETCH_READ) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  a_r7_acc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_exec && is_in && !in_valid_i) |=> $stable(acc_q));
  a_r9_no_strobe_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> !stb_q);
  a_r6_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_exec && opc == OP_JMP) |=> (pc_q == $past(opa)));

endmodule

// File: tb/nac_cpu_tb.sv
module nac_cpu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_wait, out_stb, halted;
  logic [7:0] out_data;
  logic [2:0] phase;

  int n_cmp = 0;
  int n_bad = 0;

  // results of the last run
  int         r_nstb;
  logic [7:0] r_out;
  int         r_stall_bad;
  int         r_waits;

  always #10 clk = ~clk;

  nac_cpu u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_en_i(load_en), .load_addr_i(load_addr), .load_data_i(load_data),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .in_wait_o(in_wait), .out_data_o(out_data), .out_stb_o(out_stb),
    .halted_o(halted), .phase_o(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic wipe();
    for (int i = 0; i < 16; i++) poke(4'(i), 8'h00);
  endtask

  // release reset and run until halt; one input value supplied after dly waits
  task automatic run(input logic [7:0] val, input int dly);
    int  w;
    bit  given;
    w = 0; given = 0;
    r_nstb = 0; r_out = 8'h00; r_stall_bad = 0; r_waits = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3000 && !halted; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_stb) begin r_nstb++; r_out = out_data; end
      if (in_wait && !given) begin
        r_waits++;
        if (phase != 3'd4 || halted || out_stb) r_stall_bad++;
        if (w == dly) begin
          in_valid = 1'b1; in_data = val; given = 1;
        end else w++;
      end
    end
    chk("R9 run reached halt", int'(halted), 1);
  endtask

  // vector table: a, b, subtract, expected
  localparam logic [24:0] VEC [6] = '{
    {8'h05, 8'h03, 1'b0, 8'h08},
    {8'h7F, 8'h01, 1'b0, 8'h80},
    {8'hFF, 8'h01, 1'b0, 8'h00},
    {8'h03, 8'h05, 1'b1, 8'hFE},
    {8'h80, 8'h01, 1'b1, 8'h7F},
    {8'h10, 8'h10, 1'b1, 8'h00}
  };

  // branch program: IN; <br> 5; OUT; HLT; -; LDA 14; OUT; HLT ; [14]=77
  task automatic branch_case(input logic [3:0] opc, input logic [7:0] v,
                             input bit taken, input string req);
    hold_reset();
    wipe();
    poke(4'd0, 8'h91);
    poke(4'd1, {opc, 4'd5});
    poke(4'd2, 8'h92);
    poke(4'd3, 8'h00);
    poke(4'd5, 8'h5E);
    poke(4'd6, 8'h92);
    poke(4'd7, 8'h00);
    poke(4'd14, 8'h77);
    run(v, 0);
    chk(req, int'(r_out), taken ? 32'h77 : int'(v));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] a, b, e;
    logic       s;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 strobe in reset", int'(out_stb), 0);

    // R3 R4: arithmetic vectors. Program IN; ADD/SUB 15; OUT; HLT
    for (int k = 0; k < 6; k++) begin
      {a, b, s, e} = VEC[k];
      hold_reset();
      wipe();
      poke(4'd0, 8'h91);
      poke(4'd1, s ? 8'h2F : 8'h1F);
      poke(4'd2, 8'h92);
      poke(4'd3, 8'h00);
      poke(4'd15, b);
      run(a, k);
      chk("R4 wrap arithmetic result", int'(r_out), int'(e));
      chk("R8 one strobe per output", r_nstb, 1);
    end

    // R2: phase walk for LDA 15; HLT
    hold_reset();
    wipe();
    poke(4'd0, 8'h5F);
    poke(4'd1, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int exp_ph [12] = '{0, 1, 2, 3, 4, 5, 0, 1, 2, 3, 4, 6};
      for (int i = 0; i < 12; i++) begin
        chk("R2 phase order", int'(phase), exp_ph[i]);
        @(negedge clk);
      end
    end
    // R9: stays halted, no strobes
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (!halted || phase != 3'd6 || out_stb) bad++;
        @(negedge clk);
      end
      chk("R9 halt is sticky", bad, 0);
    end

    // R6: branches
    branch_case(4'b0111, 8'h00, 1, "R6 branch-if-zero taken on 0");
    branch_case(4'b0111, 8'h05, 0, "R6 branch-if-zero skipped on 5");
    branch_case(4'b1000, 8'h00, 1, "R6 branch-if-positive taken on 0");
    branch_case(4'b1000, 8'h80, 0, "R6 branch-if-positive skipped on 80");
    branch_case(4'b1000, 8'h7F, 1, "R6 branch-if-positive taken on 7F");
    branch_case(4'b0110, 8'h80, 1, "R6 branch always");

    // R5: IN; STA 12; LDA 13; LDA 12; OUT; HLT
    hold_reset();
    wipe();
    poke(4'd0, 8'h91);
    poke(4'd1, 8'h3C);
    poke(4'd2, 8'h5D);
    poke(4'd3, 8'h5C);
    poke(4'd4, 8'h92);
    poke(4'd5, 8'h00);
    run(8'h3A, 30);
    chk("R5 store then load", int'(r_out), 32'h3A);
    // R7: long stall
    chk("R7 stall seen", int'(r_waits > 25), 1);
    chk("R7 phase held while waiting", r_stall_bad, 0);

    // R1: RAM survives reset; reload only code words
    hold_reset();
    poke(4'd0, 8'h5C);
    poke(4'd1, 8'h92);
    poke(4'd2, 8'h00);
    run(8'h00, 0);
    chk("R1 RAM kept through reset", int'(r_out), 32'h3A);

    // R10: preload overrides earlier content
    hold_reset();
    poke(4'd12, 8'hC4);
    run(8'h00, 0);
    chk("R10 preload value read back", int'(r_out), 32'hC4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule